// File: doc/BRIEF.md
# LED Matrix Row-Scan PWM Sequencer

This block times a multiplexed LED matrix of up to `N_SW` switch (row) lines by `N_CS` sink (column) lines. It lights one switch line at a time and, while a line is lit, produces a pulse-width-modulated enable for every sink column. The pulse width comes from the per-dot 8-bit duty array. The per-dot scaling array acts only as an enable: a dot with a zero scaling byte stays dark. Current magnitude is not produced here.

Every switch slot has three phases, all timed by a timebase tick (nominally 1 MHz):
- an all-off gap of `GAP_TICKS` ticks;
- a lead-in of `LEAD_TICKS` ticks, during which the line is on but the sinks stay off;
- a drive window of `DRIVE_TICKS` ticks, which holds 256 PWM positions.

The PWM position is the tick count within the drive window, with the block-clock count since the last tick appended as its low bits. The block clock must therefore run at 2^(PWM_W - log2(DRIVE_TICKS)) times the tick rate, which is 8 with the defaults.

A 4-bit mode field selects how many lines are scanned, or turns scanning off. A run bit blanks all sinks without stopping the scan. Every line also has a weak-resistor enable that is on exactly when that line is not driven.

The block has no data stream: the duty and scaling arrays are read as static buses. The tick and configuration inputs are plain level or strobe pins, with no handshake and no back-pressure.

Top module: `matrix_scan_seq`

## Requirements
- R1: While reset is asserted, all `sw_n` bits are 1, all `cs_en` bits are 0, and every `sw_pd_en` and `cs_pu_en` bit is 1.
- R2: In scan modes, at most one switch line is active (low) at a time. Each line stays active for (LEAD_TICKS+DRIVE_TICKS) ticks, which is 272 clocks with the defaults. Consecutive slots are separated by an all-off gap of GAP_TICKS ticks (16 clocks), and the active line never changes without that gap.
- R3: For the first LEAD_TICKS ticks (16 clocks) after a switch line turns active, every sink enable is 0. PWM then starts at position 0.
- R4: Lines are lit in ascending index order from 0 up to the last active line, then wrap to 0. Leaving the no-scan mode restarts the order at line 0.
- R5: Mode codes 0 to 3 and 9 to 15 scan all N_SW lines. Codes 4, 5, 6 and 7 scan N_SW-1, N_SW-2, N_SW-3 and N_SW-4 lines. Lines above the active count are never activated. A new code takes effect at the end of the current drive window.
- R6: Mode code 8 stops scanning. All `sw_n` bits stay 1, and each sink pulses continuously with the line-0 duty byte, with a period of 256 clocks and no gap or lead-in.
- R7: In a slot for line l, `cs_en[k]` is high for exactly D clocks, where D is the duty byte for dot (l,k) located at bits [(l*N_CS+k)*8 +: 8] of `pwm_flat`. D=0 gives no pulse and D=255 gives 255 of 256 positions.
- R8: A dot whose scaling byte (same bit position in `scale_flat`) is zero produces no sink pulse, whatever its duty byte.
- R9: While `cfg_run` is 0, all sinks are off from the next clock on, and the switch lines keep scanning.
- R10: `sw_pd_en[i]` is 1 exactly when `sw_n[i]` is 1, and `cs_pu_en[k]` is 1 exactly when `cs_en[k]` is 0.
- R11: A line's duty and scaling bytes are captured at the end of the gap before its slot. Changes made later in that slot do not affect its pulses; they take effect the next time the line is lit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, 8x the tick rate with the defaults |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock timebase strobe |
| cfg_mode | input | 4 | Scan mode code |
| cfg_run | input | 1 | 1 = sinks may drive, 0 = matrix blanked |
| pwm_flat | input | N_SW*N_CS*8 | Per-dot duty bytes |
| scale_flat | input | N_SW*N_CS*8 | Per-dot scaling bytes (non-zero = dot enabled) |
| sw_n | output | N_SW | Active-low switch line enables |
| sw_pd_en | output | N_SW | Switch line pull-down enables |
| cs_en | output | N_CS | Sink enables |
| cs_pu_en | output | N_CS | Sink line pull-up enables |

## Verification
A wrong phase or tick count shows up within one slot: the line's active time, the gap before the next line, or the offset of the first sink pulse differs from 272, 16 or 16 clocks. A wrong line index or mode decode shows up at the next slot boundary, when an unexpected line lights, or an expected one fails to light, in the ascending order. Faults in the PWM position counter or the row capture show up as sink high-time totals per slot that differ from the duty bytes. A dot whose enable was taken from the wrong byte, or a duty change that leaks into the current slot, is seen by the end of that slot.

// File: rtl/mxs_pkg.sv
package mxs_pkg;
  typedef enum logic [1:0] {
    PH_GAP   = 2'd0,
    PH_LEAD  = 2'd1,
    PH_DRIVE = 2'd2
  } phase_t;

  localparam logic [3:0] MODE_STATIC = 4'd8;
endpackage

// File: rtl/mxs_timer.sv
module mxs_timer
  import mxs_pkg::*;
#(
  parameter int N_SW        = 6,
  parameter int GAP_TICKS   = 2,
  parameter int LEAD_TICKS  = 2,
  parameter int DRIVE_TICKS = 32,
  parameter int PWM_W       = 8,
  localparam int IW         = $clog2(N_SW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [3:0]       mode_code,
  output logic             lit_o,
  output logic             drive_o,
  output logic [IW-1:0]    line_o,
  output logic [PWM_W-1:0] pos_o,
  output logic             load_o,
  output logic [IW-1:0]    load_line_o
);
  localparam int TW = $clog2(DRIVE_TICKS);
  localparam int SW = PWM_W - TW;
  localparam int CW = TW + 1;
  localparam int LW = $clog2(N_SW + 1);

  phase_t         phase;
  logic [CW-1:0]  tcnt;
  logic [SW-1:0]  sub;
  logic [IW-1:0]  line;
  logic           static_q;
  logic [LW-1:0]  lines_sel;
  logic [LW-1:0]  line_inc;
  logic           gap_end, lead_end, drive_end, go_static;

  always_comb begin
    case (mode_code)
      4'd4:    lines_sel = LW'(N_SW - 1);
      4'd5:    lines_sel = LW'(N_SW - 2);
      4'd6:    lines_sel = LW'(N_SW - 3);
      4'd7:    lines_sel = LW'(N_SW - 4);
      default: lines_sel = LW'(N_SW);
    endcase
  end

  assign line_inc  = LW'(line) + LW'(1);
  assign gap_end   = (tcnt == CW'(GAP_TICKS - 1));
  assign lead_end  = (tcnt == CW'(LEAD_TICKS - 1));
  assign drive_end = (tcnt == CW'(DRIVE_TICKS - 1));
  assign go_static = (mode_code == MODE_STATIC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_GAP;
      tcnt     <= '0;
      sub      <= '0;
      line     <= '0;
      static_q <= 1'b0;
    end else begin
      if (tick)          sub <= '0;
      else if (sub != '1) sub <= sub + 1'b1;
      if (tick) begin
        case (phase)
          PH_GAP: begin
            if (gap_end) begin
              phase <= PH_LEAD;
              tcnt  <= '0;
            end else tcnt <= tcnt + 1'b1;
          end
          PH_LEAD: begin
            if (lead_end) begin
              phase <= PH_DRIVE;
              tcnt  <= '0;
            end else tcnt <= tcnt + 1'b1;
          end
          PH_DRIVE: begin
            if (drive_end) begin
              tcnt <= '0;
              if (go_static) begin
                phase    <= PH_DRIVE;
                line     <= '0;
                static_q <= 1'b1;
              end else begin
                phase    <= PH_GAP;
                static_q <= 1'b0;
                line     <= (static_q || line_inc >= lines_sel) ? '0 : IW'(line_inc);
              end
            end else tcnt <= tcnt + 1'b1;
          end
          default: phase <= PH_GAP;
        endcase
      end
    end
  end

  assign load_o      = tick && ((phase == PH_GAP && gap_end) ||
                                (phase == PH_DRIVE && drive_end && go_static));
  assign load_line_o = (phase == PH_GAP) ? line : '0;
  assign lit_o       = (phase != PH_GAP) && !static_q;
  assign drive_o     = (phase == PH_DRIVE);
  assign line_o      = line;
  assign pos_o       = {tcnt[TW-1:0], sub};
endmodule

// File: rtl/mxs_row_latch.sv
module mxs_row_latch #(
  parameter int N_SW  = 6,
  parameter int N_CS  = 30,
  parameter int PWM_W = 8,
  localparam int IW   = $clog2(N_SW),
  localparam int AW   = N_SW * N_CS * PWM_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [IW-1:0]         line,
  input  logic [AW-1:0]         pwm_all,
  input  logic [AW-1:0]         scale_all,
  output logic [N_CS*PWM_W-1:0] duty_o,
  output logic [N_CS-1:0]       en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_o <= '0;
      en_o   <= '0;
    end else if (load) begin
      for (int k = 0; k < N_CS; k++) begin
        duty_o[k*PWM_W +: PWM_W] <= pwm_all[(int'(line)*N_CS + k)*PWM_W +: PWM_W];
        en_o[k]                  <= |scale_all[(int'(line)*N_CS + k)*PWM_W +: PWM_W];
      end
    end
  end
endmodule

// File: rtl/mxs_sink_cell.sv
module mxs_sink_cell #(
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PWM_W-1:0] duty,
  input  logic             dot_en,
  input  logic [PWM_W-1:0] pos,
  input  logic             drive,
  input  logic             run,
  output logic             sink_o,
  output logic             pull_o
);
  logic on;
  assign on = run && drive && dot_en && (pos < duty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sink_o <= 1'b0;
      pull_o <= 1'b1;
    end else begin
      sink_o <= on;
      pull_o <= !on;
    end
  end
endmodule

// File: rtl/matrix_scan_seq.sv
module matrix_scan_seq #(
  parameter int N_SW        = 6,
  parameter int N_CS        = 30,
  parameter int PWM_W       = 8,
  parameter int GAP_TICKS   = 2,
  parameter int LEAD_TICKS  = 2,
  parameter int DRIVE_TICKS = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick,
  input  logic [3:0]                    cfg_mode,
  input  logic                          cfg_run,
  input  logic [N_SW*N_CS*PWM_W-1:0]    pwm_flat,
  input  logic [N_SW*N_CS*PWM_W-1:0]    scale_flat,
  output logic [N_SW-1:0]               sw_n,
  output logic [N_SW-1:0]               sw_pd_en,
  output logic [N_CS-1:0]               cs_en,
  output logic [N_CS-1:0]               cs_pu_en
);
  localparam int IW = $clog2(N_SW);

  logic             lit, drive, load;
  logic [IW-1:0]    line, load_line;
  logic [PWM_W-1:0] pos;
  logic [N_CS*PWM_W-1:0] row_duty;
  logic [N_CS-1:0]  row_en;
  logic [N_SW-1:0]  sw_n_q, sw_pd_q;

  mxs_timer #(
    .N_SW(N_SW), .GAP_TICKS(GAP_TICKS), .LEAD_TICKS(LEAD_TICKS),
    .DRIVE_TICKS(DRIVE_TICKS), .PWM_W(PWM_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_code(cfg_mode),
    .lit_o(lit), .drive_o(drive), .line_o(line), .pos_o(pos),
    .load_o(load), .load_line_o(load_line)
  );

  mxs_row_latch #(.N_SW(N_SW), .N_CS(N_CS), .PWM_W(PWM_W)) u_row (
    .clk(clk), .rst_n(rst_n), .load(load), .line(load_line),
    .pwm_all(pwm_flat), .scale_all(scale_flat),
    .duty_o(row_duty), .en_o(row_en)
  );

  for (genvar k = 0; k < N_CS; k++) begin : g_sink
    mxs_sink_cell #(.PWM_W(PWM_W)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .duty(row_duty[k*PWM_W +: PWM_W]), .dot_en(row_en[k]),
      .pos(pos), .drive(drive), .run(cfg_run),
      .sink_o(cs_en[k]), .pull_o(cs_pu_en[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_n_q  <= '1;
      sw_pd_q <= '1;
    end else begin
      for (int i = 0; i < N_SW; i++) begin
        sw_n_q[i]  <= !(lit && line == IW'(i));
        sw_pd_q[i] <= !(lit && line == IW'(i));
      end
    end
  end

  assign sw_n     = sw_n_q;
  assign sw_pd_en = sw_pd_q;
endmodule

// File: rtl/mxs_checker.sv
module mxs_checker #(
  parameter int N_SW = 6,
  parameter int N_CS = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_run,
  input logic [N_SW-1:0] sw_n,
  input logic [N_CS-1:0] cs_en
);
  p_single_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~sw_n));

  p_gap_between_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~sw_n) != '0 && $past(~sw_n) != '0) |-> (sw_n == $past(sw_n)));

  p_sink_lead_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((~sw_n) != '0 && $past(sw_n) == '1) |-> (cs_en == '0));

  p_blank_when_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_run |=> (cs_en == '0));
endmodule

bind matrix_scan_seq mxs_checker #(.N_SW(N_SW), .N_CS(N_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .sw_n(sw_n), .cs_en(cs_en)
);

// File: tb/sim_matrix_scan_seq.sv
module sim_matrix_scan_seq;
  localparam int N_SW = 6;
  localparam int N_CS = 30;
  localparam int PW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [3:0] cfg_mode = 4'd0;
  logic cfg_run = 1'b1;
  logic [N_SW*N_CS*PW-1:0] pwm_flat = '0;
  logic [N_SW*N_CS*PW-1:0] scale_flat = '0;
  logic [N_SW-1:0] sw_n, sw_pd_en;
  logic [N_CS-1:0] cs_en, cs_pu_en;

  always #2.5 clk = ~clk;

  matrix_scan_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_mode(cfg_mode), .cfg_run(cfg_run),
    .pwm_flat(pwm_flat), .scale_flat(scale_flat),
    .sw_n(sw_n), .sw_pd_en(sw_pd_en), .cs_en(cs_en), .cs_pu_en(cs_pu_en)
  );

  int tests = 0;
  int fails = 0;
  int pull_bad = 0;
  int pwm_m [N_SW][N_CS];
  int scl_m [N_SW][N_CS];

  int    exp_line[$];
  int    exp_cnt[$];
  string exp_tag[$];

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      repeat (7) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // monitor: pops one expected slot at each slot start, compares at its end
  logic [N_SW-1:0] cur_mask;
  bit in_slot = 0, have_exp = 0, overlap_bad = 0;
  int gap_len = 0, act_len = 0, first_on = -1, e_line = 0;
  int cnt [N_CS];
  int e_cnt [N_CS];
  string e_tag [N_CS];

  always @(negedge clk) begin
    logic [N_SW-1:0] act;
    act = ~sw_n;
    if (!rst_n) begin
      in_slot = 0;
      gap_len = 0;
    end else begin
      if (sw_pd_en !== sw_n || cs_pu_en !== ~cs_en) pull_bad++;
      if (act != '0 && !in_slot) begin
        int obs;
        in_slot = 1; cur_mask = act; act_len = 0; first_on = -1; overlap_bad = 0;
        for (int k = 0; k < N_CS; k++) cnt[k] = 0;
        have_exp = (exp_line.size() > 0);
        if (have_exp) begin
          e_line = exp_line.pop_front();
          for (int k = 0; k < N_CS; k++) begin
            e_cnt[k] = exp_cnt.pop_front();
            e_tag[k] = exp_tag.pop_front();
          end
          chk("R2 gap clocks", gap_len, 16);
          obs = -1;
          if ($countones(act) == 1)
            for (int i = 0; i < N_SW; i++) if (act[i]) obs = i;
          chk("R4/R5 lit line", obs, e_line);
        end
      end
      if (in_slot && act != '0) begin
        if (act != cur_mask) overlap_bad = 1;
        act_len++;
        for (int k = 0; k < N_CS; k++) if (cs_en[k]) cnt[k]++;
        if (cs_en != '0 && first_on < 0) first_on = act_len - 1;
      end
      if (in_slot && act == '0) begin
        in_slot = 0;
        if (have_exp) begin
          int any_on;
          any_on = 0;
          chk("R2 active clocks", act_len, 272);
          chk("R2 no line switch", int'(overlap_bad), 0);
          for (int k = 0; k < N_CS; k++) begin
            if (e_cnt[k] > 0) any_on = 1;
            chk(e_tag[k], cnt[k], e_cnt[k]);
          end
          chk("R3 first sink offset", first_on, any_on ? 16 : -1);
        end
      end
      if (act == '0) gap_len++; else gap_len = 0;
    end
  end

  task automatic apply();
    for (int l = 0; l < N_SW; l++)
      for (int k = 0; k < N_CS; k++) begin
        pwm_flat[(l*N_CS+k)*PW +: PW]   = PW'(pwm_m[l][k]);
        scale_flat[(l*N_CS+k)*PW +: PW] = PW'(scl_m[l][k]);
      end
  endtask

  task automatic fill(input int seed);
    for (int l = 0; l < N_SW; l++)
      for (int k = 0; k < N_CS; k++) begin
        pwm_m[l][k] = (l*53 + k*29 + seed*17 + 7) % 256;
        scl_m[l][k] = ((l + k + seed) % 7 == 3) ? 0 : 1 + (l*k + seed) % 200;
      end
    pwm_m[0][0] = 255; scl_m[0][0] = 255;
    pwm_m[0][1] = 1;   scl_m[0][1] = 9;
    pwm_m[1][1] = 0;   scl_m[1][1] = 50;
    pwm_m[2][3] = 200; scl_m[2][3] = 0;
    apply();
  endtask

  task automatic push_frame(input int nlines, input string tag);
    for (int l = 0; l < nlines; l++) begin
      exp_line.push_back(l);
      for (int k = 0; k < N_CS; k++) begin
        if (!cfg_run) begin
          exp_cnt.push_back(0); exp_tag.push_back("R9 sink blanked");
        end else if (scl_m[l][k] == 0) begin
          exp_cnt.push_back(0); exp_tag.push_back("R8 disabled dot");
        end else begin
          exp_cnt.push_back(pwm_m[l][k]); exp_tag.push_back(tag);
        end
      end
    end
  endtask

  task automatic wait_slot_end();
    do @(negedge clk); while (sw_n === '1);
    do @(negedge clk); while (sw_n !== '1);
  endtask

  task automatic wait_line_end(input int l);
    do @(negedge clk); while (sw_n[l] !== 1'b0);
    do @(negedge clk); while (sw_n !== '1);
  endtask

  task automatic run_scan(input logic [3:0] code, input int nlines, input string tag);
    cfg_mode = code;
    wait_slot_end();
    wait_line_end(nlines - 1);
    push_frame(nlines, tag);
    wait_line_end(nlines - 1);
    chk({tag, " queue drained"}, exp_line.size(), 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 sw_n idle", int'(sw_n === '1), 1);
    chk("R1 cs_en idle", int'(cs_en === '0), 1);
    chk("R1 pulls on", int'(sw_pd_en === '1 && cs_pu_en === '1), 1);
    fill(0);
    rst_n = 1'b1;

    run_scan(4'd0, 6, "R7 duty code0");
    fill(1);
    run_scan(4'd3, 6, "R7 duty code3");
    run_scan(4'd5, 4, "R5 four lines");
    run_scan(4'd7, 2, "R5 two lines");
    fill(2);
    run_scan(4'd4, 5, "R5 five lines");
    run_scan(4'd12, 6, "R5 other code");

    cfg_run = 1'b0;
    run_scan(4'd0, 6, "R9 scan continues");
    cfg_run = 1'b1;

    // R11: change line 0 data in the middle of its slot
    fill(3);
    cfg_mode = 4'd0;
    wait_slot_end();
    wait_line_end(5);
    push_frame(6, "R11 old data kept");
    do @(negedge clk); while (sw_n[0] !== 1'b0);
    repeat (100) @(negedge clk);
    for (int k = 0; k < N_CS; k++) pwm_m[0][k] = (k * 7 + 3) % 256;
    apply();
    for (int k = 0; k < N_CS; k++) pwm_m[0][k] = (pwm_m[0][k] + 0) % 256;
    wait_line_end(5);
    push_frame(6, "R11 new data next slot");
    wait_line_end(5);
    chk("R11 queue drained", exp_line.size(), 0);

    // R6: no-scan mode, line 0 data, 256-clock period
    fill(4);
    cfg_mode = 4'd8;
    repeat (700) @(negedge clk);
    begin
      int sc [N_CS];
      int sw_seen;
      sw_seen = 0;
      for (int k = 0; k < N_CS; k++) sc[k] = 0;
      for (int t = 0; t < 1024; t++) begin
        @(negedge clk);
        if (sw_n !== '1) sw_seen++;
        for (int k = 0; k < N_CS; k++) if (cs_en[k]) sc[k]++;
      end
      chk("R6 switches idle", sw_seen, 0);
      for (int k = 0; k < N_CS; k++)
        chk("R6 static sink", sc[k], scl_m[0][k] == 0 ? 0 : 4 * pwm_m[0][k]);
    end

    run_scan(4'd0, 6, "R4 restart after static");
    chk("R10 pull enables", pull_bad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule